// File: doc/BRIEF.md
# Page Buffer Write-Cycle Engine

This block sits between a serial-bus slave controller and a byte-wide memory array. While a write transaction is on the bus, each accepted data byte goes into a small page latch of `PAGE_BYTES` entries rather than into the array. The first accepted byte fixes the page and the starting slot. Each later byte lands in the next slot of that page, and the slot number wraps inside the page.

When the bus side reports a clean end of transaction on `commit_i`, the engine raises `busy_o` and runs a self-timed programming interval of `WRITE_CYCLES` clocks. It then copies every loaded slot into the array, one slot per clock and in ascending slot order. After that it drops `busy_o`. The bus controller withholds the acknowledge of device-select bytes while `busy_o` is high, so a master can poll for completion. A pulse on `abort_i` discards the latch contents. Bytes aimed at the upper half of the array while `wr_lock_i` is high are refused and never reach the array.

Top module: `pbw_engine`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are both low.
- R2: Loaded bytes are written to the array only after a commit. A pulse on `abort_i` while idle empties the latch, so a later commit writes nothing.
- R3: A commit while idle with at least one slot loaded sets `busy_o` high in the next cycle. `busy_o` then stays high for exactly WRITE_CYCLES + PAGE_BYTES + 1 cycles.
- R4: During a commit, each loaded slot is written exactly once and unloaded slots are not written. Writes come one per cycle in ascending slot order. The address is {page bits taken from the first accepted byte, slot number in the low log2(PAGE_BYTES) bits}, and the data is the latest byte stored in that slot.
- R5: The slot of the first accepted byte is the low log2(PAGE_BYTES) bits of its address. Each later accepted byte goes to the previous slot plus one, modulo PAGE_BYTES. A byte reaching an already loaded slot replaces its data.
- R6: While `wr_lock_i` is high, a byte is refused if the top address bit of its page is 1 (the page bits of the first accepted byte, or of `ld_addr_i` when the latch is empty). A refused byte is not stored and does not advance the slot counter. Pages with top bit 0 are unaffected by the lock.
- R7: A commit while the latch is empty is ignored: `busy_o` stays low and nothing is written.
- R8: While `busy_o` is high, loads, aborts and commits have no effect.
- R9: `mem_we_o` is high only in cycles where `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid_i | input | 1 | A data byte is offered for the latch |
| ld_addr_i | input | ADDR_W | Array address of the offered byte (used in full for the first byte) |
| ld_data_i | input | DATA_W | Offered data byte |
| wr_lock_i | input | 1 | Protects the upper half of the array from loading |
| commit_i | input | 1 | Clean end of write transaction: start the programming cycle |
| abort_i | input | 1 | Transaction broken off: drop the latched bytes |
| busy_o | output | 1 | Programming cycle in progress; device select must not be acknowledged |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
Four rules are checked on every cycle: writes occur only inside the busy window, busy rises only after a commit, each busy window has exactly the stated length, and the writes within a window stay in one page with strictly rising slot numbers. The scenarios must show the rest. These are the wrap-around overwrite of slots, refused bytes under the lock not advancing the counter, an abort emptying the latch, and loads, aborts and commits issued during a busy window leaving no trace. The bench shows these by comparing every array write with a queue of expected writes and by watching `busy_o` after each commit.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PROG = 2'd1,
    PH_SCAN = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/pbw_latch.sv
module pbw_latch #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [DATA_W-1:0]     ld_data,
  input  logic                  wr_lock,
  input  logic                  abort,
  input  logic                  hold,
  input  logic                  clear,
  input  logic                  rd_en,
  input  logic [OFF_W-1:0]      rd_idx,
  output logic [PAGE_BYTES-1:0] slot_valid,
  output logic                  any_loaded,
  output logic [PAGE_W-1:0]     page_base,
  output logic [DATA_W-1:0]     rd_data
);
  logic [DATA_W-1:0] store [PAGE_BYTES];
  logic [OFF_W-1:0]  next_off;
  logic              top_half;
  logic [OFF_W-1:0]  wr_off;
  logic              accept;

  // Page of the transaction: from the first accepted byte, else from the offered address
  assign top_half = any_loaded ? page_base[PAGE_W-1] : ld_addr[ADDR_W-1];
  assign wr_off   = any_loaded ? next_off : ld_addr[OFF_W-1:0];
  assign accept   = ld_valid && !hold && !abort && !(wr_lock && top_half);

  // Data store: no reset, one write port, registered read port
  always_ff @(posedge clk) begin
    if (accept) store[wr_off] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_idx];
  end

  // Bookkeeping of loaded slots and the page counter
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= '0;
      any_loaded <= 1'b0;
      page_base  <= '0;
      next_off   <= '0;
    end else if (clear || (abort && !hold)) begin
      slot_valid <= '0;
      any_loaded <= 1'b0;
      next_off   <= '0;
    end else if (accept) begin
      slot_valid[wr_off] <= 1'b1;
      next_off           <= wr_off + OFF_W'(1);
      any_loaded         <= 1'b1;
      if (!any_loaded) page_base <= ld_addr[ADDR_W-1:OFF_W];
    end
  end
endmodule

// File: rtl/pbw_sequencer.sv
module pbw_sequencer
  import pbw_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 8,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int TMR_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  commit,
  input  logic                  any_loaded,
  input  logic [PAGE_BYTES-1:0] slot_valid,
  output logic                  busy,
  output logic                  scan_en,
  output logic [OFF_W-1:0]      scan_idx,
  output logic                  clear,
  output logic                  we,
  output logic [OFF_W-1:0]      we_off
);
  localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(PAGE_BYTES - 1);
  localparam logic [TMR_W-1:0] LAST_TICK = TMR_W'(WRITE_CYCLES - 1);

  phase_t           phase;
  logic [TMR_W-1:0] tmr;

  assign scan_en = (phase == PH_SCAN);
  assign clear   = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      busy     <= 1'b0;
      tmr      <= '0;
      scan_idx <= '0;
      we       <= 1'b0;
      we_off   <= '0;
    end else begin
      we <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (commit && any_loaded) begin
            phase <= PH_PROG;
            busy  <= 1'b1;
            tmr   <= '0;
          end
        end
        PH_PROG: begin
          if (tmr == LAST_TICK) begin
            phase    <= PH_SCAN;
            scan_idx <= '0;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        PH_SCAN: begin
          we       <= slot_valid[scan_idx];
          we_off   <= scan_idx;
          scan_idx <= scan_idx + OFF_W'(1);
          if (scan_idx == LAST_SLOT) phase <= PH_DONE;
        end
        PH_DONE: begin
          busy  <= 1'b0;
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbw_engine.sv
module pbw_engine #(
  parameter int ADDR_W       = 9,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              wr_lock_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_BYTES-1:0] slot_valid;
  logic                  any_loaded;
  logic [PAGE_W-1:0]     page_base;
  logic                  scan_en;
  logic [OFF_W-1:0]      scan_idx;
  logic                  clear;
  logic [OFF_W-1:0]      we_off;

  pbw_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_latch (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid_i), .ld_addr(ld_addr_i), .ld_data(ld_data_i),
    .wr_lock(wr_lock_i), .abort(abort_i), .hold(busy_o), .clear(clear),
    .rd_en(scan_en), .rd_idx(scan_idx),
    .slot_valid(slot_valid), .any_loaded(any_loaded),
    .page_base(page_base), .rd_data(mem_wdata_o)
  );

  pbw_sequencer #(
    .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst),
    .commit(commit_i), .any_loaded(any_loaded), .slot_valid(slot_valid),
    .busy(busy_o), .scan_en(scan_en), .scan_idx(scan_idx), .clear(clear),
    .we(mem_we_o), .we_off(we_off)
  );

  // Page bits are held stable for the whole busy window
  assign mem_addr_o = {page_base, we_off};
endmodule

// File: rtl/pbw_engine_chk.sv
module pbw_engine_chk #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              commit_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int BUSY_LEN = WRITE_CYCLES + PAGE_BYTES + 1;

  logic [31:0]      busy_cnt;
  logic             seen_we;
  logic [OFF_W-1:0] last_off;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else     busy_cnt <= busy_o ? busy_cnt + 32'd1 : 32'd0;
  end

  always_ff @(posedge clk) begin
    if (rst || !busy_o) begin
      seen_we  <= 1'b0;
      last_off <= '0;
    end else if (mem_we_o) begin
      seen_we  <= 1'b1;
      last_off <= mem_addr_o[OFF_W-1:0];
    end
  end

  a_r9_we_inside_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);

  a_r3_busy_after_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(commit_i));

  a_r3_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> busy_cnt == 32'(BUSY_LEN));

  a_r4_slots_rising: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && seen_we) |-> mem_addr_o[OFF_W-1:0] > last_off);

  a_r4_one_page: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && $past(mem_we_o)) |->
      mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W]));
endmodule

bind pbw_engine pbw_engine_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .commit_i(commit_i), .busy_o(busy_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/pbw_engine_tb.sv
module pbw_engine_tb;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int PAGE   = 16;
  localparam int WCYC   = 8;
  localparam int OFF_W  = 4;
  localparam int BLEN   = WCYC + PAGE + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic wr_lock = 1'b0;
  logic commit = 1'b0;
  logic abort = 1'b0;
  logic busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  always #5 clk = ~clk;

  pbw_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst(rst), .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .wr_lock_i(wr_lock), .commit_i(commit), .abort_i(abort), .busy_o(busy),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata));

  int n_chk = 0;
  int n_bad = 0;
  logic [ADDR_W+DATA_W-1:0] exp_q[$];

  // Bench-side model of the latch, built from the requirements
  logic [DATA_W-1:0] m_img [PAGE];
  logic [PAGE-1:0]   m_v = '0;
  logic              m_has = 1'b0;
  logic [ADDR_W-OFF_W-1:0] m_base = '0;
  logic [OFF_W-1:0]  m_off = '0;

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    finish_run();
  end

  // Monitor: every array write is popped from the scoreboard
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      n_chk++;
      if (!busy) begin
        n_bad++;
        $display("FAIL R9: write outside busy, actual %0h expected %0h", busy, 1);
      end
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2/R4: unexpected write, actual %0h expected %0h", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [ADDR_W+DATA_W-1:0] e;
        e = exp_q.pop_front();
        if (e != {mem_addr, mem_wdata}) begin
          n_bad++;
          $display("FAIL R4/R5: write, actual %0h expected %0h", {mem_addr, mem_wdata}, e);
        end
      end
    end
  end

  task automatic load(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic lk);
    logic top;
    logic [OFF_W-1:0] o;
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d; wr_lock = lk;
    if (!busy) begin
      top = m_has ? m_base[ADDR_W-OFF_W-1] : a[ADDR_W-1];
      if (!(lk && top)) begin
        o = m_has ? m_off : a[OFF_W-1:0];
        if (!m_has) m_base = a[ADDR_W-1:OFF_W];
        m_img[o] = d; m_v[o] = 1'b1; m_has = 1'b1;
        m_off = o + 4'd1;
      end
    end
    @(negedge clk);
    ld_valid = 1'b0; wr_lock = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk);
    abort = 1'b1;
    if (!busy) begin m_v = '0; m_has = 1'b0; end
    @(negedge clk);
    abort = 1'b0;
  endtask

  task automatic do_commit(input string tag);
    int n;
    logic had;
    had = m_has;
    if (had)
      for (int i = 0; i < PAGE; i++)
        if (m_v[i]) exp_q.push_back({m_base, 4'(i), m_img[i]});
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    chk(busy == had, {tag, " R3/R7 busy after commit"}, busy, had);
    if (had) begin
      n = 1;
      while (busy && n < 1000) begin
        @(negedge clk);
        if (busy) n++;
      end
      chk(n == BLEN, {tag, " R3 busy length"}, n, BLEN);
      m_v = '0; m_has = 1'b0;
    end else begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(!busy, {tag, " R7 stays idle"}, busy, 0);
      end
    end
    @(negedge clk);
    chk(exp_q.size() == 0, {tag, " R4 all expected writes seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(mem_we == 1'b0, "R1 we after reset", mem_we, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1 idle after release", busy, 0);

    // R4: short burst in middle of a page
    for (int i = 0; i < 4; i++) load(9'h023 + 9'(i), 8'hA0 + 8'(i), 1'b0);
    do_commit("R4 burst");

    // R5: 18 bytes from slot 14, wrap overwrites slots 14 and 15
    for (int i = 0; i < 18; i++) load(9'h05E, 8'h10 + 8'(i), 1'b0);
    do_commit("R5 wrap");

    // R2: bytes loaded but not committed never appear
    for (int i = 0; i < 3; i++) load(9'h070, 8'h55, 1'b0);
    repeat (40) @(negedge clk);
    chk(!busy, "R2 no commit no busy", busy, 0);
    do_abort();
    do_commit("R2 after abort");

    // R7: commit with an empty latch
    do_commit("R7 empty");

    // R6: locked upper half refuses, counter not advanced
    load(9'h143, 8'hE1, 1'b1);
    load(9'h144, 8'hE2, 1'b1);
    do_commit("R6 all refused");
    load(9'h140, 8'hC0, 1'b1);
    load(9'h140, 8'hC1, 1'b0);
    load(9'h140, 8'hC2, 1'b1);
    load(9'h140, 8'hC3, 1'b0);
    do_commit("R6 mixed");
    load(9'h0F8, 8'h77, 1'b1);
    load(9'h0F8, 8'h78, 1'b1);
    do_commit("R6 lower half unlocked");

    // R8: activity during busy has no effect
    load(9'h031, 8'h31, 1'b0);
    for (int i = 0; i < PAGE; i++)
      if (m_v[i]) exp_q.push_back({m_base, 4'(i), m_img[i]});
    m_v = '0; m_has = 1'b0;
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    chk(busy, "R8 busy started", busy, 1);
    load(9'h002, 8'h99, 1'b0);
    do_abort();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R8 only original write", exp_q.size(), 0);
    do_commit("R8 nothing latched during busy");

    finish_run();
  end
endmodule